// File: doc/BRIEF.md
# Stride-2 Transposed Convolution Phase Splitter

This block lets a plain stride-1 convolution engine carry out a stride-2 transposed convolution without any zero insertion. While a kernel of side K (2 to KMAX) is streamed in row-major order, every weight is sent to one of four phase sub-kernels, picked by the parity of its row and column. The weight's position inside that sub-kernel is half its position in the full kernel. For each phase it also gives the row and lane enable masks that match the sub-kernel's true size, which differs by phase when K is odd.

Each phase sub-kernel is convolved at stride 1 with the unpadded input map. The engine returns all four phase results together, one spatial position per beat, in raster order over the H x W input grid. The block turns each beat into four write addresses that interleave the phases into a 2H x 2W output map. This needs address arithmetic only. A small controller steps through idle, kernel load, result stream and done, and takes a new configuration only while it is idle.

Top module: `tconv_phase_splitter`

## Requirements
- R1: A `start_i` pulse while idle, with a valid configuration, sets `busy_o` at the next edge and captures `ksize_i`, `in_h_i` and `in_w_i`. A `start_i` while busy is ignored, and the captured configuration and masks stay unchanged.
- R2: While loading, the n-th valid weight is taken to be kernel element (r,c) with n = r*K + c. One cycle later it appears on `wt_data_o` with `wt_valid_o` high, `wt_sub_o` = 2*(r mod 2) + (c mod 2), `wt_row_o` = r/2 and `wt_col_o` = c/2 (integer division).
- R3: After K*K weights the block leaves the load phase. Any further `weight_valid_i` then gives no `wt_valid_o`.
- R4: For phase s = 2p+q, bits [s*SUB_MAX +: SUB_MAX] of `row_en_o` have their lowest ceil((K-p)/2) bits set and the rest clear. SUB_MAX = ceil(KMAX/2).
- R5: For phase s = 2p+q, bits [s*SUB_MAX +: SUB_MAX] of `lane_en_o` have their lowest ceil((K-q)/2) bits set and the rest clear.
- R6: For the beat at input position (i,j), with beats in raster order over the captured H x W, slice s of `out_addr_o` (bits [s*ADDR_W +: ADDR_W]) equals (2i+p)*(2W) + 2j + q.
- R7: `out_valid_o` is high in the cycle after each accepted `res_valid_i` and low otherwise. `out_data_o` then equals the `res_data_i` of that beat, with phase s in bits [s*RW +: RW].
- R8: `done_o` is high for exactly the one cycle that presents the last (H*W-th) beat. The block is idle with `busy_o` low in the next cycle.
- R9: A `start_i` with `ksize_i` outside 2..KMAX, or with a zero height or width, is ignored and the block stays idle.
- R10: After reset the block is idle, every valid and done output is low, and both masks are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a layer pass |
| ksize_i | input | KW | Kernel side K |
| in_h_i | input | DIM_W | Input map height H |
| in_w_i | input | DIM_W | Input map width W |
| weight_valid_i | input | 1 | Kernel weight strobe |
| weight_i | input | WW | Kernel weight, row-major order |
| res_valid_i | input | 1 | Four phase results present |
| res_data_i | input | 4*RW | Phase results, phase s in slice s |
| busy_o | output | 1 | Not idle |
| done_o | output | 1 | Last beat presented |
| row_en_o | output | 4*SUB_MAX | Row enables per phase |
| lane_en_o | output | 4*SUB_MAX | Lane enables per phase |
| wt_valid_o | output | 1 | Routed weight valid |
| wt_sub_o | output | 2 | Target phase sub-kernel |
| wt_row_o | output | SPW | Row inside the sub-kernel |
| wt_col_o | output | SPW | Column inside the sub-kernel |
| wt_data_o | output | WW | Routed weight |
| out_valid_o | output | 1 | Output beat valid |
| out_addr_o | output | 4*ADDR_W | Interleaved write address per phase |
| out_data_o | output | 4*RW | Phase results for those addresses |

## Verification
Some properties are checked on every cycle. These are the start handshake, and that a bad configuration is refused. A routed weight or output beat must always follow an input strobe by one cycle. An odd phase column must always produce an odd address and an even one an even address. The masks must be nested across phases and must stay fixed while busy, and done must be a single-cycle pulse. Other things can only be shown by the bench's sweeps over every kernel size and several map shapes. These are the exact parity routing of each weight and the exact mask widths. The bench also checks the full address formula at every beat, that the end of the load and stream phases is counted correctly, and that a restart or extra weights arriving mid-pass change nothing.

// File: rtl/tconv_pkg.sv
package tconv_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_STREAM, ST_DONE} tconv_state_e;
  localparam int NPHASE = 4;
endpackage

// File: rtl/tconv_weight_router.sv
module tconv_weight_router #(
  parameter int KW  = 3,
  parameter int SPW = 2,
  parameter int WW  = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           en_i,
  input  logic [KW-1:0]  ksize_i,
  input  logic [WW-1:0]  weight_i,
  output logic           last_o,
  output logic           wt_valid_o,
  output logic [1:0]     wt_sub_o,
  output logic [SPW-1:0] wt_row_o,
  output logic [SPW-1:0] wt_col_o,
  output logic [WW-1:0]  wt_data_o
);
  logic [KW-1:0] r_q, c_q, kmax_idx;
  logic          row_end;

  assign kmax_idx = ksize_i - KW'(1);
  assign row_end  = (c_q == kmax_idx);
  assign last_o   = en_i && row_end && (r_q == kmax_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q        <= '0;
      c_q        <= '0;
      wt_valid_o <= 1'b0;
      wt_sub_o   <= '0;
      wt_row_o   <= '0;
      wt_col_o   <= '0;
      wt_data_o  <= '0;
    end else if (clr_i) begin
      r_q        <= '0;
      c_q        <= '0;
      wt_valid_o <= 1'b0;
    end else begin
      wt_valid_o <= en_i;
      if (en_i) begin
        wt_sub_o  <= {r_q[0], c_q[0]};
        wt_row_o  <= SPW'(r_q >> 1);
        wt_col_o  <= SPW'(c_q >> 1);
        wt_data_o <= weight_i;
        if (row_end) begin
          c_q <= '0;
          r_q <= r_q + KW'(1);
        end else begin
          c_q <= c_q + KW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/tconv_mask_gen.sv
module tconv_mask_gen #(
  parameter int KW      = 3,
  parameter int SUB_MAX = 3
) (
  input  logic [KW-1:0]          ksize_i,
  output logic [4*SUB_MAX-1:0]   row_en_o,
  output logic [4*SUB_MAX-1:0]   lane_en_o
);
  // Phase parity p keeps ceil((K-p)/2) taps: tap b is live when 2b+p < K.
  for (genvar s = 0; s < tconv_pkg::NPHASE; s++) begin : g_phase
    localparam int P = s / 2;
    localparam int Q = s % 2;
    for (genvar b = 0; b < SUB_MAX; b++) begin : g_tap
      assign row_en_o[s*SUB_MAX+b]  = (2*b + P) < int'(ksize_i);
      assign lane_en_o[s*SUB_MAX+b] = (2*b + Q) < int'(ksize_i);
    end
  end
endmodule

// File: rtl/tconv_addr_gen.sv
module tconv_addr_gen #(
  parameter int DIM_W  = 6,
  parameter int ADDR_W = 14,
  parameter int RW     = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 en_i,
  input  logic [DIM_W-1:0]     in_h_i,
  input  logic [DIM_W-1:0]     in_w_i,
  input  logic [4*RW-1:0]      res_data_i,
  output logic                 last_o,
  output logic                 out_valid_o,
  output logic [4*ADDR_W-1:0]  out_addr_o,
  output logic [4*RW-1:0]      out_data_o
);
  logic [DIM_W-1:0]    i_q, j_q;
  logic                col_end;
  logic [ADDR_W-1:0]   pitch;
  logic [4*ADDR_W-1:0] addr_d;

  assign col_end = (j_q == in_w_i - DIM_W'(1));
  assign last_o  = en_i && col_end && (i_q == in_h_i - DIM_W'(1));
  assign pitch   = ADDR_W'({in_w_i, 1'b0});

  for (genvar s = 0; s < tconv_pkg::NPHASE; s++) begin : g_addr
    localparam int P = s / 2;
    localparam int Q = s % 2;
    assign addr_d[s*ADDR_W +: ADDR_W] =
        ADDR_W'({i_q, 1'(P)}) * pitch + ADDR_W'({j_q, 1'(Q)});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_q         <= '0;
      j_q         <= '0;
      out_valid_o <= 1'b0;
      out_addr_o  <= '0;
      out_data_o  <= '0;
    end else if (clr_i) begin
      i_q         <= '0;
      j_q         <= '0;
      out_valid_o <= 1'b0;
    end else begin
      out_valid_o <= en_i;
      if (en_i) begin
        out_addr_o <= addr_d;
        out_data_o <= res_data_i;
        if (col_end) begin
          j_q <= '0;
          i_q <= i_q + DIM_W'(1);
        end else begin
          j_q <= j_q + DIM_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/tconv_phase_splitter.sv
module tconv_phase_splitter #(
  parameter int KMAX  = 5,
  parameter int WW    = 8,
  parameter int DIM_W = 6,
  parameter int RW    = 16,
  localparam int KW      = $clog2(KMAX + 1),
  localparam int SUB_MAX = (KMAX + 1) / 2,
  localparam int SPW     = (SUB_MAX > 1) ? $clog2(SUB_MAX) : 1,
  localparam int ADDR_W  = 2 * DIM_W + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [KW-1:0]        ksize_i,
  input  logic [DIM_W-1:0]     in_h_i,
  input  logic [DIM_W-1:0]     in_w_i,
  input  logic                 weight_valid_i,
  input  logic [WW-1:0]        weight_i,
  input  logic                 res_valid_i,
  input  logic [4*RW-1:0]      res_data_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [4*SUB_MAX-1:0] row_en_o,
  output logic [4*SUB_MAX-1:0] lane_en_o,
  output logic                 wt_valid_o,
  output logic [1:0]           wt_sub_o,
  output logic [SPW-1:0]       wt_row_o,
  output logic [SPW-1:0]       wt_col_o,
  output logic [WW-1:0]        wt_data_o,
  output logic                 out_valid_o,
  output logic [4*ADDR_W-1:0]  out_addr_o,
  output logic [4*RW-1:0]      out_data_o
);
  import tconv_pkg::*;

  tconv_state_e     state_q, state_d;
  logic [KW-1:0]    k_q;
  logic [DIM_W-1:0] h_q, w_q;
  logic             cfg_ok, accept, idle;
  logic             wt_en, wt_last, res_en, res_last;

  assign idle   = (state_q == ST_IDLE);
  assign cfg_ok = (ksize_i >= KW'(2)) && (int'(ksize_i) <= KMAX) &&
                  (in_h_i != '0) && (in_w_i != '0);
  assign accept = idle && start_i && cfg_ok;
  assign wt_en  = (state_q == ST_LOAD) && weight_valid_i;
  assign res_en = (state_q == ST_STREAM) && res_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept)   state_d = ST_LOAD;
      ST_LOAD:   if (wt_last)  state_d = ST_STREAM;
      ST_STREAM: if (res_last) state_d = ST_DONE;
      ST_DONE:                 state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      k_q     <= '0;
      h_q     <= '0;
      w_q     <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        k_q <= ksize_i;
        h_q <= in_h_i;
        w_q <= in_w_i;
      end
    end
  end

  assign busy_o = !idle;
  assign done_o = (state_q == ST_DONE);

  tconv_mask_gen #(.KW(KW), .SUB_MAX(SUB_MAX)) u_mask (
    .ksize_i   (k_q),
    .row_en_o  (row_en_o),
    .lane_en_o (lane_en_o)
  );

  tconv_weight_router #(.KW(KW), .SPW(SPW), .WW(WW)) u_route (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (idle),
    .en_i       (wt_en),
    .ksize_i    (k_q),
    .weight_i   (weight_i),
    .last_o     (wt_last),
    .wt_valid_o (wt_valid_o),
    .wt_sub_o   (wt_sub_o),
    .wt_row_o   (wt_row_o),
    .wt_col_o   (wt_col_o),
    .wt_data_o  (wt_data_o)
  );

  tconv_addr_gen #(.DIM_W(DIM_W), .ADDR_W(ADDR_W), .RW(RW)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (idle),
    .en_i        (res_en),
    .in_h_i      (h_q),
    .in_w_i      (w_q),
    .res_data_i  (res_data_i),
    .last_o      (res_last),
    .out_valid_o (out_valid_o),
    .out_addr_o  (out_addr_o),
    .out_data_o  (out_data_o)
  );
endmodule

// File: rtl/tconv_phase_splitter_chk.sv
module tconv_phase_splitter_chk #(
  parameter int KMAX    = 5,
  parameter int DIM_W   = 6,
  parameter int KW      = 3,
  parameter int SUB_MAX = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic [KW-1:0]        ksize_i,
  input logic [DIM_W-1:0]     in_h_i,
  input logic [DIM_W-1:0]     in_w_i,
  input logic                 weight_valid_i,
  input logic                 res_valid_i,
  input logic                 busy_o,
  input logic                 done_o,
  input logic [4*SUB_MAX-1:0] row_en_o,
  input logic [4*SUB_MAX-1:0] lane_en_o,
  input logic                 wt_valid_o,
  input logic                 out_valid_o,
  input logic                 addr0_lsb,
  input logic                 addr1_lsb
);
  logic good_cfg;
  assign good_cfg = (ksize_i >= KW'(2)) && (int'(ksize_i) <= KMAX) &&
                    (in_h_i != '0) && (in_w_i != '0);

  p_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && good_cfg) |=> busy_o);
  p_bad_cfg_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !good_cfg) |=> !busy_o);
  p_wt_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wt_valid_o |-> $past(weight_valid_i) && $past(busy_o));
  p_row_nest_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((row_en_o[2*SUB_MAX +: SUB_MAX] & ~row_en_o[0 +: SUB_MAX]) == '0) &&
    ((row_en_o[3*SUB_MAX +: SUB_MAX] & ~row_en_o[SUB_MAX +: SUB_MAX]) == '0));
  p_lane_nest_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lane_en_o[SUB_MAX +: SUB_MAX] & ~lane_en_o[0 +: SUB_MAX]) == '0) &&
    ((lane_en_o[3*SUB_MAX +: SUB_MAX] & ~lane_en_o[2*SUB_MAX +: SUB_MAX]) == '0));
  p_mask_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(row_en_o) && $stable(lane_en_o)));
  p_addr_parity_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (!addr0_lsb && addr1_lsb));
  p_out_follows_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(res_valid_i));
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
endmodule

bind tconv_phase_splitter tconv_phase_splitter_chk #(
  .KMAX(KMAX), .DIM_W(DIM_W), .KW(KW), .SUB_MAX(SUB_MAX)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .ksize_i        (ksize_i),
  .in_h_i         (in_h_i),
  .in_w_i         (in_w_i),
  .weight_valid_i (weight_valid_i),
  .res_valid_i    (res_valid_i),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .row_en_o       (row_en_o),
  .lane_en_o      (lane_en_o),
  .wt_valid_o     (wt_valid_o),
  .out_valid_o    (out_valid_o),
  .addr0_lsb      (out_addr_o[0]),
  .addr1_lsb      (out_addr_o[ADDR_W])
);

// File: tb/sim_tconv_phase_splitter.sv
module sim_tconv_phase_splitter;
  localparam int KMAX = 5, WW = 8, DIM_W = 6, RW = 16;
  localparam int KW = 3, SUB_MAX = 3, SPW = 2, ADDR_W = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, wv = 1'b0, rv = 1'b0;
  logic [KW-1:0] ksize = '0;
  logic [DIM_W-1:0] in_h = '0, in_w = '0;
  logic [WW-1:0] weight = '0;
  logic [4*RW-1:0] res_data = '0;
  logic busy, done, wt_valid, out_valid;
  logic [4*SUB_MAX-1:0] row_en, lane_en;
  logic [1:0] wt_sub;
  logic [SPW-1:0] wt_row, wt_col;
  logic [WW-1:0] wt_data;
  logic [4*ADDR_W-1:0] out_addr;
  logic [4*RW-1:0] out_data;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  tconv_phase_splitter u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ksize_i(ksize),
    .in_h_i(in_h), .in_w_i(in_w), .weight_valid_i(wv), .weight_i(weight),
    .res_valid_i(rv), .res_data_i(res_data), .busy_o(busy), .done_o(done),
    .row_en_o(row_en), .lane_en_o(lane_en), .wt_valid_o(wt_valid),
    .wt_sub_o(wt_sub), .wt_row_o(wt_row), .wt_col_o(wt_col), .wt_data_o(wt_data),
    .out_valid_o(out_valid), .out_addr_o(out_addr), .out_data_o(out_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4*SUB_MAX-1:0] exp_mask(input int k, input bit use_col);
    logic [4*SUB_MAX-1:0] m = '0;
    for (int s = 0; s < 4; s++) begin
      int par = use_col ? (s % 2) : (s / 2);
      int n = (k - par + 1) / 2;
      for (int b = 0; b < SUB_MAX; b++) m[s*SUB_MAX+b] = (b < n);
    end
    return m;
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic try_bad(input int k, input int h, input int w);
    @(negedge clk); start = 1'b1; ksize = KW'(k); in_h = DIM_W'(h); in_w = DIM_W'(w);
    step(); start = 1'b0;
    chk(!busy, "R9 bad config refused", busy, 0);
  endtask

  task automatic run_case(input int k, input int h, input int w);
    logic [4*SUB_MAX-1:0] er, el;
    @(negedge clk); start = 1'b1; ksize = KW'(k); in_h = DIM_W'(h); in_w = DIM_W'(w);
    step(); start = 1'b0;
    chk(busy, "R1 start accepted", busy, 1);
    er = exp_mask(k, 1'b0); el = exp_mask(k, 1'b1);
    chk(row_en == er, "R4 row mask", row_en, er);
    chk(lane_en == el, "R5 lane mask", lane_en, el);
    // R1: restart while busy must not reload config
    @(negedge clk); start = 1'b1; ksize = KW'((k == 2) ? 5 : 2);
    step(); start = 1'b0;
    chk(busy && row_en == er && lane_en == el, "R1 restart ignored", row_en, er);
    for (int r = 0; r < k; r++)
      for (int c = 0; c < k; c++) begin
        logic [2+2*SPW+WW:0] ea, aa;
        @(negedge clk); wv = 1'b1; weight = WW'(r*16 + c);
        step();
        ea = {1'b1, 2'(2*(r%2) + (c%2)), SPW'(r/2), SPW'(c/2), WW'(r*16 + c)};
        aa = {wt_valid, wt_sub, wt_row, wt_col, wt_data};
        chk(aa == ea, "R2 weight routing", aa, ea);
      end
    @(negedge clk); wv = 1'b1; weight = 8'hff;
    step(); wv = 1'b0;
    chk(!wt_valid, "R3 extra weight dropped", wt_valid, 0);
    step();
    chk(!out_valid, "R7 no beat without strobe", out_valid, 0);
    for (int i = 0; i < h; i++)
      for (int j = 0; j < w; j++) begin
        logic [4*ADDR_W-1:0] ea;
        logic [4*RW-1:0] ed;
        bit last = (i == h-1) && (j == w-1);
        for (int s = 0; s < 4; s++) begin
          ea[s*ADDR_W +: ADDR_W] = ADDR_W'((2*i + s/2) * (2*w) + 2*j + s%2);
          ed[s*RW +: RW] = RW'(i*1000 + j*10 + s);
        end
        @(negedge clk); rv = 1'b1; res_data = ed;
        step(); rv = 1'b0;
        chk(out_valid && out_data == ed, "R7 beat data", out_data, ed);
        chk(out_addr == ea, "R6 interleave address", out_addr, ea);
        chk(done == last, "R8 done timing", done, last);
      end
    step();
    chk(!busy && !done, "R8 back to idle", {busy, done}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk({busy, done, wt_valid, out_valid} == 4'b0, "R10 reset outputs",
        {busy, done, wt_valid, out_valid}, 0);
    chk(row_en == '0 && lane_en == '0, "R10 reset masks", row_en, 0);
    @(negedge clk); rst_n = 1'b1;
    try_bad(1, 2, 2);
    try_bad(6, 2, 2);
    try_bad(0, 2, 2);
    try_bad(3, 0, 2);
    try_bad(3, 2, 0);
    for (int k = 2; k <= KMAX; k++) begin
      run_case(k, 2, 3);
      run_case(k, 3, 2);
      run_case(k, 1, 1);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule